// File: doc/BRIEF.md
# Accumulator ALU with Sign, Zero, Carry and Overflow Status

This block is the arithmetic and logic unit of a small accumulator datapath. Each operation takes the current accumulator value, a second operand, an operation code and the current status word. A one-cycle strobe launches it. On the next clock edge the block presents the new accumulator value and the updated status word, and raises a valid flag for that cycle.

The block supports eight operations:
- add with carry
- subtract with borrow
- AND, OR and exclusive OR
- compare
- shift left, which is arithmetic
- shift right, which is logical

A decimal-mode bit in the status word switches add and subtract to packed two-digit BCD. In that mode the sign and overflow bits still come from the uncorrected binary sum. The block does no instruction decoding and no memory access. The surrounding core feeds it operands and status, and stores what comes back.

Control is a two-state sequencer. In `S_IDLE` no result is being presented. In `S_DONE` a fresh result is on the outputs. A strobe in either state moves the sequencer to `S_DONE` and loads the result. A cycle without a strobe moves it to `S_IDLE`, and the outputs keep their last values.

Top module: `acc_alu8`

## Requirements
- R1: A result is registered on the clock edge that samples `start` high, and `valid` is high for the cycle after each such edge. After an edge with `start` low, `valid` is low, and `acc_out` and `stat_out` keep their values whatever the other inputs do.
- R2: While `rst_n` is low, `acc_out`, `stat_out` and `valid` are all zero. The status bit positions are carry 0, zero 1, decimal 2, overflow 3 and sign 4.
- R3: The operation codes are 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 compare, 6 shift left and 7 shift right. In binary mode, add computes A+M+C and subtract computes A+~M+C. For both, the carry bit is the carry out of bit 7, so for subtract carry=1 means no borrow.
- R4: After add or subtract, overflow is 1 exactly when the two addends (A and M, or A and ~M) have the same bit 7 and the raw binary sum has a different bit 7.
- R5: After add, subtract, AND, OR or XOR, the sign bit equals bit 7 of the raw 8-bit binary result.
- R6: AND, OR and XOR leave the carry and overflow bits unchanged.
- R7: Compare leaves the accumulator unchanged and leaves the overflow bit unchanged. It ignores the incoming carry. It sets carry when A ≥ M as unsigned numbers, and takes sign and zero from A−M.
- R8: Shift left moves old bit 7 into carry and shifts a zero into bit 0. The sign bit becomes old bit 6. Overflow is unchanged.
- R9: Shift right moves old bit 0 into carry and shifts a zero into bit 7. The sign bit is always cleared. Overflow is unchanged.
- R10: With decimal = 1, add and subtract work digit by digit on 4-bit BCD digits. For add, a digit sum above 9 gets 6 added and carries into the next digit. For subtract, a digit that borrows gets 6 taken away. The carry bit is the decimal carry out of the top digit, and for subtract it means no borrow.
- R11: In decimal mode, the sign bit and the overflow bit come from the uncorrected binary sum, not from the corrected value.
- R12: The zero bit is 1 exactly when the value written to the accumulator is zero, except after compare, where it reflects the difference. The decimal bit passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch strobe; one operation per cycle it is high |
| op_sel | input | 3 | Operation code (see R3) |
| acc_in | input | 8 | Current accumulator value A |
| opnd | input | 8 | Second operand M |
| stat_in | input | 5 | Current status word {sign, overflow, decimal, zero, carry} |
| acc_out | output | 8 | New accumulator value |
| stat_out | output | 5 | New status word, same layout as `stat_in` |
| valid | output | 1 | High in the cycle a fresh result is presented |

## Verification
Two things can fall in the same cycle: presenting one result (`S_DONE`) and accepting the next strobe. The bench provokes this by holding `start` high through its whole vector table, so every operation arrives while the previous result is still on the outputs. It judges each new result in the following cycle and expects `valid` to stay high throughout. It then drops the strobe while it changes the operands, and checks that the final result stays put and that `valid` falls.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_ADC = 3'd0,
        OP_SBC = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_CMP = 3'd5,
        OP_ASL = 3'd6,
        OP_LSR = 3'd7
    } alu_op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_DONE = 1'b1
    } seq_state_e;

    localparam int ST_W  = 5;
    localparam int F_CAR = 0;
    localparam int F_ZER = 1;
    localparam int F_DEC = 2;
    localparam int F_OVF = 3;
    localparam int F_NEG = 4;

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int DIGITS = 2,
    localparam int WIDTH = 4 * DIGITS
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] m,
    input  logic             cin,
    input  logic             sub,
    input  logic             cmp,
    output logic [WIDTH-1:0] bin_res,
    output logic             bin_c,
    output logic             bin_v,
    output logic [WIDTH-1:0] dec_res,
    output logic             dec_c
);

    logic             sub_eff;
    logic             cin_eff;
    logic [WIDTH-1:0] addend;
    logic [WIDTH:0]   full;

    assign sub_eff = sub | cmp;
    assign cin_eff = cmp ? 1'b1 : cin;
    assign addend  = sub_eff ? ~m : m;
    assign full    = {1'b0, a} + {1'b0, addend} + {{WIDTH{1'b0}}, cin_eff};
    assign bin_res = full[WIDTH-1:0];
    assign bin_c   = full[WIDTH];
    assign bin_v   = (a[WIDTH-1] == addend[WIDTH-1]) && (full[WIDTH-1] != a[WIDTH-1]);

    // Digit-serial decimal correction; link carries a carry (add) or a borrow (sub).
    always_comb begin
        logic       link;
        logic [4:0] s5;
        logic [4:0] d5;
        logic [3:0] ad;
        logic [3:0] md;
        link    = sub ? ~cin : cin;
        dec_res = '0;
        for (int i = 0; i < DIGITS; i++) begin
            ad = a[4*i +: 4];
            md = m[4*i +: 4];
            s5 = {1'b0, ad} + {1'b0, md} + {4'b0000, link};
            d5 = {1'b0, ad} - {1'b0, md} - {4'b0000, link};
            if (sub) begin
                link               = d5[4];
                dec_res[4*i +: 4]  = d5[4] ? (d5[3:0] - 4'd6) : d5[3:0];
            end else begin
                link               = (s5 > 5'd9);
                dec_res[4*i +: 4]  = (s5 > 5'd9) ? (s5[3:0] + 4'd6) : s5[3:0];
            end
        end
        dec_c = sub ? ~link : link;
    end

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops import alu_pkg::*; #(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] m,
    output logic [WIDTH-1:0] res,
    output logic             c_out
);

    always_comb begin
        res   = '0;
        c_out = 1'b0;
        unique case (op)
            OP_AND: res = a & m;
            OP_OR:  res = a | m;
            OP_XOR: res = a ^ m;
            OP_ASL: {c_out, res} = {a, 1'b0};
            OP_LSR: begin
                res   = {1'b0, a[WIDTH-1:1]};
                c_out = a[0];
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/alu_flag_mux.sv
module alu_flag_mux import alu_pkg::*; #(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [ST_W-1:0]  st,
    input  logic [WIDTH-1:0] bin_res,
    input  logic             bin_c,
    input  logic             bin_v,
    input  logic [WIDTH-1:0] dec_res,
    input  logic             dec_c,
    input  logic [WIDTH-1:0] bit_res,
    input  logic             bit_c,
    output logic [WIDTH-1:0] nxt_acc,
    output logic [ST_W-1:0]  nxt_st
);

    logic neg, ovf, car, zer;

    always_comb begin
        nxt_acc = a;
        neg     = st[F_NEG];
        ovf     = st[F_OVF];
        car     = st[F_CAR];
        unique case (op)
            OP_ADC, OP_SBC: begin
                nxt_acc = st[F_DEC] ? dec_res : bin_res;
                car     = st[F_DEC] ? dec_c : bin_c;
                neg     = bin_res[WIDTH-1];
                ovf     = bin_v;
            end
            OP_AND, OP_OR, OP_XOR: begin
                nxt_acc = bit_res;
                neg     = bit_res[WIDTH-1];
            end
            OP_CMP: begin
                nxt_acc = a;
                neg     = bin_res[WIDTH-1];
                car     = bin_c;
            end
            OP_ASL: begin
                nxt_acc = bit_res;
                neg     = a[WIDTH-2];
                car     = bit_c;
            end
            OP_LSR: begin
                nxt_acc = bit_res;
                neg     = 1'b0;
                car     = bit_c;
            end
            default: nxt_acc = a;
        endcase
        zer = (op == OP_CMP) ? (bin_res == '0) : (nxt_acc == '0);
        nxt_st = '0;
        nxt_st[F_NEG] = neg;
        nxt_st[F_OVF] = ovf;
        nxt_st[F_DEC] = st[F_DEC];
        nxt_st[F_ZER] = zer;
        nxt_st[F_CAR] = car;
    end

endmodule

// File: rtl/acc_alu8.sv
module acc_alu8 import alu_pkg::*; #(
    parameter int DIGITS = 2,
    localparam int WIDTH = 4 * DIGITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op_sel,
    input  logic [WIDTH-1:0] acc_in,
    input  logic [WIDTH-1:0] opnd,
    input  logic [ST_W-1:0]  stat_in,
    output logic [WIDTH-1:0] acc_out,
    output logic [ST_W-1:0]  stat_out,
    output logic             valid
);

    alu_op_e          op_e;
    seq_state_e       state, state_nxt;
    logic [WIDTH-1:0] bin_res, dec_res, bit_res, nxt_acc;
    logic             bin_c, bin_v, dec_c, bit_c;
    logic [ST_W-1:0]  nxt_st;

    assign op_e = alu_op_e'(op_sel);

    alu_arith #(.DIGITS(DIGITS)) u_arith (
        .a       (acc_in),
        .m       (opnd),
        .cin     (stat_in[F_CAR]),
        .sub     (op_e == OP_SBC),
        .cmp     (op_e == OP_CMP),
        .bin_res (bin_res),
        .bin_c   (bin_c),
        .bin_v   (bin_v),
        .dec_res (dec_res),
        .dec_c   (dec_c)
    );

    alu_bitops #(.WIDTH(WIDTH)) u_bits (
        .op    (op_e),
        .a     (acc_in),
        .m     (opnd),
        .res   (bit_res),
        .c_out (bit_c)
    );

    alu_flag_mux #(.WIDTH(WIDTH)) u_flags (
        .op      (op_e),
        .a       (acc_in),
        .st      (stat_in),
        .bin_res (bin_res),
        .bin_c   (bin_c),
        .bin_v   (bin_v),
        .dec_res (dec_res),
        .dec_c   (dec_c),
        .bit_res (bit_res),
        .bit_c   (bit_c),
        .nxt_acc (nxt_acc),
        .nxt_st  (nxt_st)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: state_nxt = start ? S_DONE : S_IDLE;
            S_DONE: state_nxt = start ? S_DONE : S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_out  <= '0;
            stat_out <= '0;
        end else if (start) begin
            acc_out  <= nxt_acc;
            stat_out <= nxt_st;
        end
    end

    assign valid = (state == S_DONE);

endmodule

// File: rtl/acc_alu8_chk.sv
module acc_alu8_chk import alu_pkg::*; #(
    parameter int DIGITS = 2,
    localparam int WIDTH = 4 * DIGITS
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [2:0]       op_sel,
    input logic [WIDTH-1:0] acc_in,
    input logic [ST_W-1:0]  stat_in,
    input logic [WIDTH-1:0] acc_out,
    input logic [ST_W-1:0]  stat_out,
    input logic             valid
);

    a_r1_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);

    a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !valid);

    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(acc_out) && $stable(stat_out)));

    a_r12_dec_kept: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (stat_out[F_DEC] == $past(stat_in[F_DEC])));

    a_r12_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_sel != OP_CMP) |=> (stat_out[F_ZER] == (acc_out == '0)));

    a_r9_lsr_sign_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_sel == OP_LSR) |=> !stat_out[F_NEG]);

    a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_sel == OP_CMP) |=> (acc_out == $past(acc_in)));

    a_r6_logic_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR)) |=>
        (stat_out[F_CAR] == $past(stat_in[F_CAR]) && stat_out[F_OVF] == $past(stat_in[F_OVF])));

endmodule

bind acc_alu8 acc_alu8_chk #(.DIGITS(DIGITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_sel   (op_sel),
    .acc_in   (acc_in),
    .stat_in  (stat_in),
    .acc_out  (acc_out),
    .stat_out (stat_out),
    .valid    (valid)
);

// File: tb/acc_alu8_tb.sv
module acc_alu8_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 20;

    // {op, acc_in, opnd, stat_in, exp_acc, exp_stat}; stat = {N,V,D,Z,C}
    localparam logic [36:0] VEC [NV] = '{
        {3'd0, 8'h7F, 8'h01, 5'h00, 8'h80, 5'h18},
        {3'd1, 8'h32, 8'h64, 5'h01, 8'hCE, 5'h10},
        {3'd0, 8'hFF, 8'h01, 5'h00, 8'h00, 5'h03},
        {3'd2, 8'hF0, 8'h8F, 5'h09, 8'h80, 5'h19},
        {3'd3, 8'h00, 8'h00, 5'h10, 8'h00, 5'h02},
        {3'd4, 8'hAA, 8'h55, 5'h00, 8'hFF, 5'h10},
        {3'd5, 8'h10, 8'h20, 5'h09, 8'h10, 5'h18},
        {3'd5, 8'h40, 8'h40, 5'h00, 8'h40, 5'h03},
        {3'd6, 8'h40, 8'h00, 5'h01, 8'h80, 5'h10},
        {3'd6, 8'h80, 8'h00, 5'h00, 8'h00, 5'h03},
        {3'd7, 8'h81, 8'h00, 5'h10, 8'h40, 5'h01},
        {3'd7, 8'h01, 8'h00, 5'h00, 8'h00, 5'h03},
        {3'd0, 8'h58, 8'h46, 5'h04, 8'h04, 5'h1D},
        {3'd0, 8'h79, 8'h00, 5'h05, 8'h80, 5'h04},
        {3'd1, 8'h42, 8'h13, 5'h05, 8'h29, 5'h05},
        {3'd1, 8'h10, 8'h20, 5'h05, 8'h90, 5'h14},
        {3'd1, 8'h80, 8'h01, 5'h01, 8'h7F, 5'h09},
        {3'd0, 8'h10, 8'h20, 5'h01, 8'h31, 5'h00},
        {3'd1, 8'h05, 8'h05, 5'h00, 8'hFF, 5'h10},
        {3'd5, 8'hF0, 8'h10, 5'h04, 8'hF0, 5'h15}
    };

    function automatic string vtag(int i);
        case (i)
            0:  return "R4 R5";
            1:  return "R3 R5";
            2:  return "R3 R12";
            3:  return "R6";
            4:  return "R6 R12";
            5:  return "R5";
            6:  return "R7";
            7:  return "R7";
            8:  return "R8";
            9:  return "R8";
            10: return "R9";
            11: return "R9";
            12: return "R10 R11";
            13: return "R10 R11";
            14: return "R10";
            15: return "R10 R11";
            16: return "R4";
            17: return "R3";
            18: return "R3";
            default: return "R7 R12";
        endcase
    endfunction

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] opnd = 8'h00;
    logic [4:0] stat_in = 5'h00;
    logic [7:0] acc_out;
    logic [4:0] stat_out;
    logic       valid;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu8 u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_sel   (op_sel),
        .acc_in   (acc_in),
        .opnd     (opnd),
        .stat_in  (stat_in),
        .acc_out  (acc_out),
        .stat_out (stat_out),
        .valid    (valid)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R2: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 acc_out in reset", acc_out, 8'h00);
        check("R2 stat_out in reset", {3'b0, stat_out}, 8'h00);
        check("R2 valid in reset", {7'b0, valid}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid idle after reset", {7'b0, valid}, 8'h00);

        // Back-to-back vector table, start held high
        for (int i = 0; i < NV; i++) begin
            {op_sel, acc_in, opnd, stat_in} = VEC[i][36:13];
            start = 1'b1;
            @(posedge clk);
            @(negedge clk);
            check({vtag(i), " acc"}, acc_out, VEC[i][12:5]);
            check({vtag(i), " stat"}, {3'b0, stat_out}, {3'b0, VEC[i][4:0]});
            check("R1 valid stays high", {7'b0, valid}, 8'h01);
        end

        // R1: strobe low, operands changed -> outputs hold, valid low
        start   = 1'b0;
        op_sel  = 3'd0;
        acc_in  = 8'h55;
        opnd    = 8'h11;
        stat_in = 5'h00;
        @(posedge clk);
        @(negedge clk);
        check("R1 valid low without start", {7'b0, valid}, 8'h00);
        check("R1 acc held", acc_out, 8'hF0);
        check("R1 stat held", {3'b0, stat_out}, 8'h15);
        @(posedge clk);
        @(negedge clk);
        check("R1 acc held second cycle", acc_out, 8'hF0);

        // R1: single strobe pulse
        op_sel  = 3'd3;
        acc_in  = 8'h0F;
        opnd    = 8'hF0;
        stat_in = 5'h00;
        start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R1 R5 pulse acc", acc_out, 8'hFF);
        check("R1 R5 pulse stat", {3'b0, stat_out}, 8'h10);
        check("R1 pulse valid", {7'b0, valid}, 8'h01);
        @(posedge clk);
        @(negedge clk);
        check("R1 valid falls after pulse", {7'b0, valid}, 8'h00);

        // R2: reset mid-run clears outputs
        rst_n = 1'b0;
        #1;
        check("R2 acc cleared", acc_out, 8'h00);
        check("R2 stat cleared", {3'b0, stat_out}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule